// File: doc/BRIEF.md
# Segmented MMIO Address Decoder

This block sits between a CPU's load/store unit and its memory-mapped devices. For each request it takes a 32-bit virtual address, an access size (byte, halfword or word) and a read/write direction. It strips the segment bits to form a physical address, then compares that address with sixteen programmable device windows. The first window that matches, in a fixed priority order, is selected. The block returns a one-hot device select and the offset of the access inside that window.

Alongside the select, the block keeps an access-latency register. Each request updates it with a size-dependent default or with the delay of the matching window. The CPU reads it once per access, and the read clears it. Misaligned accesses are flagged. Accesses that match no window are flagged as unmapped, and a few unmapped halfword status addresses return fixed constants. Window base, size, delay and enable are written through a configuration port while no request is in flight.

Top module: `mmio_router`

## Requirements
- R1: The physical address is the virtual address with a mask applied that is selected by virtual bits [31:29]: value 4 clears bit 31, value 5 clears bits [31:29], and every other value leaves the address unchanged.
- R2: Window n matches when it is enabled and its base <= physical address < base + size, with the sum taken without wrap. A window of size zero never matches. On a match, the offset output is the physical address minus the base.
- R3: When several windows match, the lowest index wins. Indices 0 to 15 are, in order: boot ROM, main RAM, DMA, expansion 1, expansion 2, memory control A, B and C, interrupt controller, scratchpad, graphics, sound, timers, disc, pad/serial, video decoder. Select bit n stands for window n, and at most one bit is set.
- R4: Access size is encoded as 0 = byte, 1 = halfword, 2 or 3 = word. A word access with address bits [1:0] nonzero, or a halfword access with bit 0 set, is misaligned. Byte accesses are never misaligned. A misaligned access raises the misalign flag, selects nothing, leaves the offset 0 and does not raise the unmapped flag.
- R5: Every request updates the latency register. A write first sets it to 0. A byte or halfword read first sets it to 2. A word read leaves it unchanged. An aligned access that matches a window then loads that window's delay.
- R6: An aligned access that matches no window raises the unmapped flag. An unmapped halfword read returns 0x0005 at physical 0x1F801054, 0x00C8 at 0x1F400004, 0x1FE0 at 0x1F400006, and the serial-control holding input at 0x1F80105A. Read data is 0 for every other request.
- R7: lat_o shows the latency register. A cycle with lat_rd_i high clears it at the next edge. When a request arrives in the same cycle, the clear is applied first and the request's update follows.
- R8: Select, offset, flags and read data are registered one cycle after req_valid_i, together with a one-cycle rsp_valid_o pulse. After a cycle with no request, all of these outputs are 0.
- R9: A configuration write is ignored while req_valid_i is high. After reset, every window is disabled and the latency register and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Window configuration write strobe |
| cfg_idx_i | input | IDX_W (4) | Window index to configure |
| cfg_en_i | input | 1 | Window enable value |
| cfg_base_i | input | ADDR_W (32) | Window base address |
| cfg_size_i | input | ADDR_W (32) | Window size in bytes |
| cfg_dly_i | input | DLY_W (8) | Window access delay |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Access size code |
| req_addr_i | input | ADDR_W (32) | Virtual address |
| ser_ctrl_i | input | 16 | Serial-control holding register contents |
| lat_rd_i | input | 1 | Read-and-clear of the latency register |
| lat_o | output | DLY_W (8) | Current latency register value |
| rsp_valid_o | output | 1 | Response valid pulse |
| rsp_sel_o | output | NUM_WIN (16) | One-hot device select |
| rsp_off_o | output | ADDR_W (32) | Window-relative offset |
| rsp_misalign_o | output | 1 | Misaligned access flag |
| rsp_unmapped_o | output | 1 | Unmapped access flag |
| rsp_rdata_o | output | 16 | Fallback read data |

## Verification
On every cycle, the assertions check the response pulse timing, the one-hot select, and that the misalign and unmapped flags never appear together with a select. They also check that a byte access never flags misalignment, that an unmapped write and a lone latency read leave the latency at zero, and that the configuration stays frozen while a request is pending. The bench scenarios are needed for the value-level behaviour: segment aliasing onto the same window, priority between overlapping windows, disabled and zero-size windows, the fallback constants, and the exact latency sequence, including a word read that leaves a stale value in place.

// File: rtl/mmio_router_pkg.sv
package mmio_router_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_WRD3 = 2'd3
  } acc_size_e;

  localparam logic [31:0] SEG4_MASK = 32'h7FFF_FFFF;
  localparam logic [31:0] SEG5_MASK = 32'h1FFF_FFFF;

  localparam logic [31:0] FB_STAT_ADDR = 32'h1F80_1054;
  localparam logic [31:0] FB_EXPA_ADDR = 32'h1F40_0004;
  localparam logic [31:0] FB_EXPB_ADDR = 32'h1F40_0006;
  localparam logic [31:0] FB_SCTL_ADDR = 32'h1F80_105A;
  localparam logic [15:0] FB_STAT_VAL  = 16'h0005;
  localparam logic [15:0] FB_EXPA_VAL  = 16'h00C8;
  localparam logic [15:0] FB_EXPB_VAL  = 16'h1FE0;
endpackage

// File: rtl/mmio_seg_fold.sv
module mmio_seg_fold
  import mmio_router_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] va_i,
  output logic [ADDR_W-1:0] pa_o
);
  localparam int SEG_LSB = ADDR_W - 3;

  logic [2:0]        seg;
  logic [ADDR_W-1:0] mask;

  assign seg = va_i[ADDR_W-1:SEG_LSB];

  always_comb begin
    unique case (seg)
      3'd4:    mask = ADDR_W'(SEG4_MASK);
      3'd5:    mask = ADDR_W'(SEG5_MASK);
      default: mask = '1;
    endcase
  end

  assign pa_o = va_i & mask;
endmodule

// File: rtl/mmio_win_bank.sv
module mmio_win_bank #(
  parameter int NUM_WIN = 16,
  parameter int ADDR_W  = 32,
  parameter int DLY_W   = 8,
  parameter int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_we_i,
  input  logic [IDX_W-1:0]               cfg_idx_i,
  input  logic                           cfg_en_i,
  input  logic [ADDR_W-1:0]              cfg_base_i,
  input  logic [ADDR_W-1:0]              cfg_size_i,
  input  logic [DLY_W-1:0]               cfg_dly_i,
  input  logic                           bus_busy_i,
  input  logic [ADDR_W-1:0]              pa_i,
  output logic [NUM_WIN-1:0]             hit_vec_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] off_vec_o,
  output logic [NUM_WIN-1:0][DLY_W-1:0]  dly_vec_o
);
  logic [NUM_WIN-1:0]             en_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0] size_q;
  logic [NUM_WIN-1:0][DLY_W-1:0]  dly_q;
  logic                           cfg_take;

  assign cfg_take = cfg_we_i && !bus_busy_i;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic sel_cfg;
    assign sel_cfg = cfg_take && (cfg_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[g]   <= 1'b0;
        base_q[g] <= '0;
        size_q[g] <= '0;
        dly_q[g]  <= '0;
      end else if (sel_cfg) begin
        en_q[g]   <= cfg_en_i;
        base_q[g] <= cfg_base_i;
        size_q[g] <= cfg_size_i;
        dly_q[g]  <= cfg_dly_i;
      end
    end

    // pa >= base guarantees the subtraction does not wrap; size 0 never hits
    assign off_vec_o[g] = pa_i - base_q[g];
    assign hit_vec_o[g] = en_q[g] && (pa_i >= base_q[g]) && (off_vec_o[g] < size_q[g]);
    assign dly_vec_o[g] = dly_q[g];
  end

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_busy_i |=> ($stable(en_q) && $stable(base_q) && $stable(size_q) && $stable(dly_q))); // R9
endmodule

// File: rtl/mmio_prio_pick.sv
module mmio_prio_pick #(
  parameter int NUM_WIN = 16,
  parameter int ADDR_W  = 32,
  parameter int DLY_W   = 8
) (
  input  logic [NUM_WIN-1:0]             hit_vec_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] off_vec_i,
  input  logic [NUM_WIN-1:0][DLY_W-1:0]  dly_vec_i,
  output logic [NUM_WIN-1:0]             sel_o,
  output logic                           any_o,
  output logic [ADDR_W-1:0]              off_o,
  output logic [DLY_W-1:0]               dly_o
);
  // Scan from the top down so the lowest index overrides last
  always_comb begin
    sel_o = '0;
    any_o = 1'b0;
    off_o = '0;
    dly_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) begin
        sel_o    = '0;
        sel_o[i] = 1'b1;
        any_o    = 1'b1;
        off_o    = off_vec_i[i];
        dly_o    = dly_vec_i[i];
      end
    end
  end
endmodule

// File: rtl/mmio_fallback.sv
module mmio_fallback
  import mmio_router_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pa_i,
  input  logic [15:0]       ser_ctrl_i,
  output logic              hit_o,
  output logic [15:0]       data_o
);
  always_comb begin
    hit_o  = 1'b1;
    data_o = '0;
    if (pa_i == ADDR_W'(FB_STAT_ADDR))      data_o = FB_STAT_VAL;
    else if (pa_i == ADDR_W'(FB_EXPA_ADDR)) data_o = FB_EXPA_VAL;
    else if (pa_i == ADDR_W'(FB_EXPB_ADDR)) data_o = FB_EXPB_VAL;
    else if (pa_i == ADDR_W'(FB_SCTL_ADDR)) data_o = ser_ctrl_i;
    else                                    hit_o  = 1'b0;
  end
endmodule

// File: rtl/mmio_router.sv
module mmio_router
  import mmio_router_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter int ADDR_W  = 32,
  parameter int DLY_W   = 8,
  parameter int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_en_i,
  input  logic [ADDR_W-1:0]  cfg_base_i,
  input  logic [ADDR_W-1:0]  cfg_size_i,
  input  logic [DLY_W-1:0]   cfg_dly_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [1:0]         req_size_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [15:0]        ser_ctrl_i,
  input  logic               lat_rd_i,
  output logic [DLY_W-1:0]   lat_o,
  output logic               rsp_valid_o,
  output logic [NUM_WIN-1:0] rsp_sel_o,
  output logic [ADDR_W-1:0]  rsp_off_o,
  output logic               rsp_misalign_o,
  output logic               rsp_unmapped_o,
  output logic [15:0]        rsp_rdata_o
);
  localparam logic [DLY_W-1:0] SMALL_RD_LAT = DLY_W'(2);

  logic [ADDR_W-1:0]             pa;
  logic [NUM_WIN-1:0]            hit_vec;
  logic [NUM_WIN-1:0][ADDR_W-1:0] off_vec;
  logic [NUM_WIN-1:0][DLY_W-1:0] dly_vec;
  logic [NUM_WIN-1:0]            pick_sel;
  logic                          pick_any;
  logic [ADDR_W-1:0]             pick_off;
  logic [DLY_W-1:0]              pick_dly;
  logic                          fb_hit;
  logic [15:0]                   fb_data;
  acc_size_e                     acc;
  logic                          misalign;
  logic                          mapped;
  logic                          unmapped;
  logic [DLY_W-1:0]              lat_q, lat_d;

  mmio_seg_fold #(.ADDR_W(ADDR_W)) u_fold (
    .va_i (req_addr_i),
    .pa_o (pa)
  );

  mmio_win_bank #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .DLY_W(DLY_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_idx_i  (cfg_idx_i),
    .cfg_en_i   (cfg_en_i),
    .cfg_base_i (cfg_base_i),
    .cfg_size_i (cfg_size_i),
    .cfg_dly_i  (cfg_dly_i),
    .bus_busy_i (req_valid_i),
    .pa_i       (pa),
    .hit_vec_o  (hit_vec),
    .off_vec_o  (off_vec),
    .dly_vec_o  (dly_vec)
  );

  mmio_prio_pick #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_pick (
    .hit_vec_i (hit_vec),
    .off_vec_i (off_vec),
    .dly_vec_i (dly_vec),
    .sel_o     (pick_sel),
    .any_o     (pick_any),
    .off_o     (pick_off),
    .dly_o     (pick_dly)
  );

  mmio_fallback #(.ADDR_W(ADDR_W)) u_fb (
    .pa_i       (pa),
    .ser_ctrl_i (ser_ctrl_i),
    .hit_o      (fb_hit),
    .data_o     (fb_data)
  );

  assign acc = acc_size_e'(req_size_i);

  always_comb begin
    unique case (acc)
      ACC_BYTE: misalign = 1'b0;
      ACC_HALF: misalign = pa[0];
      default:  misalign = |pa[1:0];
    endcase
  end

  assign mapped   = !misalign && pick_any;
  assign unmapped = !misalign && !pick_any;

  always_comb begin
    lat_d = lat_q;
    if (lat_rd_i) lat_d = '0;
    if (req_valid_i) begin
      if (req_write_i)                            lat_d = '0;
      else if (acc == ACC_BYTE || acc == ACC_HALF) lat_d = SMALL_RD_LAT;
      if (mapped)                                 lat_d = pick_dly;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else         lat_q <= lat_d;
  end

  assign lat_o = lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_sel_o      <= '0;
      rsp_off_o      <= '0;
      rsp_misalign_o <= 1'b0;
      rsp_unmapped_o <= 1'b0;
      rsp_rdata_o    <= '0;
    end else begin
      rsp_valid_o    <= req_valid_i;
      rsp_sel_o      <= (req_valid_i && mapped) ? pick_sel : '0;
      rsp_off_o      <= (req_valid_i && mapped) ? pick_off : '0;
      rsp_misalign_o <= req_valid_i && misalign;
      rsp_unmapped_o <= req_valid_i && unmapped;
      rsp_rdata_o    <= (req_valid_i && unmapped && !req_write_i && acc == ACC_HALF && fb_hit)
                        ? fb_data : '0;
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && rsp_sel_o == '0 && !rsp_unmapped_o && !rsp_misalign_o)); // R8
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_sel_o)); // R3
  AST_PICK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_any |-> $onehot(pick_sel)); // R3
  AST_MIS_NOSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_misalign_o |-> (rsp_sel_o == '0 && !rsp_unmapped_o && rsp_off_o == '0)); // R4
  AST_BYTE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 2'd0) |=> !rsp_misalign_o); // R4
  AST_UNMAP_NOSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_unmapped_o |-> (rsp_sel_o == '0)); // R6
  AST_WR_UNMAP_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !pick_any) |=> (lat_o == '0)); // R5
  AST_LAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_rd_i && !req_valid_i) |=> (lat_o == '0)); // R7
endmodule

// File: tb/mmio_router_tb.sv
`timescale 1ns/1ps
module mmio_router_tb;
  localparam int NW = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_idx_i = '0;
  logic        cfg_en_i = 1'b0;
  logic [31:0] cfg_base_i = '0;
  logic [31:0] cfg_size_i = '0;
  logic [7:0]  cfg_dly_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_size_i = '0;
  logic [31:0] req_addr_i = '0;
  logic [15:0] ser_ctrl_i = 16'hA5C3;
  logic        lat_rd_i = 1'b0;
  logic [7:0]  lat_o;
  logic        rsp_valid_o;
  logic [15:0] rsp_sel_o;
  logic [31:0] rsp_off_o;
  logic        rsp_misalign_o;
  logic        rsp_unmapped_o;
  logic [15:0] rsp_rdata_o;

  always #4 clk_i = ~clk_i;

  mmio_router u_dut (.*);

  int checks = 0;
  int errors = 0;

  logic        m_en   [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_size [NW];
  logic [7:0]  m_dly  [NW];
  logic [7:0]  m_lat = '0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fold(input logic [31:0] va);
    if (va[31:29] == 3'd4) return {1'b0, va[30:0]};
    if (va[31:29] == 3'd5) return {3'b000, va[28:0]};
    return va;
  endfunction

  task automatic cfg(input int idx, input logic en, input logic [31:0] base, input logic [31:0] size, input logic [7:0] dly);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 4'(idx); cfg_en_i = en;
    cfg_base_i = base; cfg_size_i = size; cfg_dly_i = dly;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    m_en[idx] = en; m_base[idx] = base; m_size[idx] = size; m_dly[idx] = dly;
  endtask

  // Issue one request, compute expectation, compare one edge later
  task automatic access(input string req, input logic wr, input logic [1:0] sz, input logic [31:0] va);
    logic [31:0] pa;
    logic        mis;
    int          win;
    logic [15:0] esel;
    logic [31:0] eoff;
    logic [15:0] erd;
    pa  = fold(va);
    mis = (sz == 2'd1) ? pa[0] : (sz >= 2'd2) ? (pa[1:0] != 2'b00) : 1'b0;
    win = -1;
    for (int i = 0; i < NW; i++)
      if (win < 0 && m_en[i] && ({32'b0, pa} >= {32'b0, m_base[i]}) &&
          ({32'b0, pa} < ({32'b0, m_base[i]} + {32'b0, m_size[i]})))
        win = i;
    esel = '0; eoff = '0; erd = '0;
    if (wr) m_lat = 8'd0;
    else if (sz <= 2'd1) m_lat = 8'd2;
    if (!mis && win >= 0) begin
      esel[win] = 1'b1;
      eoff = pa - m_base[win];
      m_lat = m_dly[win];
    end
    if (!mis && win < 0 && !wr && sz == 2'd1) begin
      case (pa)
        32'h1F80_1054: erd = 16'h0005;
        32'h1F40_0004: erd = 16'h00C8;
        32'h1F40_0006: erd = 16'h1FE0;
        32'h1F80_105A: erd = ser_ctrl_i;
        default:       erd = 16'h0000;
      endcase
    end
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_size_i = sz; req_addr_i = va;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req, "valid", 64'(rsp_valid_o), 64'd1);
    chk(req, "sel", 64'(rsp_sel_o), 64'(esel));
    chk(req, "off", 64'(rsp_off_o), 64'(eoff));
    chk(req, "misalign", 64'(rsp_misalign_o), 64'(mis));
    chk(req, "unmapped", 64'(rsp_unmapped_o), 64'(!mis && win < 0));
    chk(req, "rdata", 64'(rsp_rdata_o), 64'(erd));
    chk(req, "lat", 64'(lat_o), 64'(m_lat));
  endtask

  task automatic lat_read(input string req);
    @(negedge clk_i);
    lat_rd_i = 1'b1;
    chk(req, "lat before clear", 64'(lat_o), 64'(m_lat));
    @(negedge clk_i);
    lat_rd_i = 1'b0;
    m_lat = 8'd0;
    chk(req, "lat after clear", 64'(lat_o), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_en[i] = 1'b0; m_base[i] = '0; m_size[i] = '0; m_dly[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9", "reset valid", 64'(rsp_valid_o), 64'd0);
    chk("R9", "reset sel", 64'(rsp_sel_o), 64'd0);
    chk("R9", "reset lat", 64'(lat_o), 64'd0);
    rst_ni = 1'b1;
    // R9 all windows disabled after reset: everything unmapped
    access("R9", 1'b0, 2'd2, 32'h0000_0100);

    cfg(0,  1, 32'h1FC0_0000, 32'h0008_0000, 8'd20);
    cfg(1,  1, 32'h0000_0000, 32'h0020_0000, 8'd4);
    cfg(2,  1, 32'h1F80_1080, 32'h0000_0080, 8'd3);
    cfg(3,  1, 32'h1F00_0000, 32'h0010_0000, 8'd7);
    cfg(4,  1, 32'h1F80_2000, 32'h0000_0080, 8'd9);
    cfg(5,  1, 32'h1F80_1000, 32'h0000_0024, 8'd1);
    cfg(6,  1, 32'h1F80_1060, 32'h0000_0004, 8'd1);
    cfg(7,  1, 32'hFFFE_0130, 32'h0000_0004, 8'd1);
    cfg(8,  1, 32'h1F80_1070, 32'h0000_0008, 8'd1);
    cfg(9,  1, 32'h1F80_0000, 32'h0000_0400, 8'd0);
    cfg(10, 1, 32'h1F80_1810, 32'h0000_0008, 8'd1);
    cfg(11, 1, 32'h1F80_1C00, 32'h0000_0400, 8'd5);
    cfg(12, 1, 32'h1F80_1100, 32'h0000_0030, 8'd1);
    cfg(13, 1, 32'h1F80_1800, 32'h0000_0004, 8'd6);
    cfg(14, 1, 32'h1F80_1040, 32'h0000_0010, 8'd1);
    cfg(15, 1, 32'h1F80_1820, 32'h0000_0008, 8'd2);

    // R1 segment aliases reach the same RAM window
    access("R1", 1'b0, 2'd2, 32'h0000_1234 & 32'hFFFF_FFFC);
    access("R1", 1'b0, 2'd2, 32'h8000_1230);
    access("R1", 1'b0, 2'd2, 32'hA000_1230);
    access("R1", 1'b0, 2'd1, 32'hBFC0_0010);
    access("R1", 1'b0, 2'd1, 32'hFFFE_0130);
    // R2 edges: last byte in, first byte past the end
    access("R2", 1'b0, 2'd0, 32'h1F80_10FF);
    access("R2", 1'b0, 2'd0, 32'h1F80_1100);
    access("R2", 1'b0, 2'd0, 32'h1F80_112F);
    access("R2", 1'b0, 2'd0, 32'h1F80_1130);
    // R2 zero-size window never matches
    cfg(4, 1, 32'h1F80_2000, 32'h0, 8'd9);
    access("R2", 1'b0, 2'd0, 32'h1F80_2000);
    // R2 disabled window never matches
    cfg(4, 0, 32'h1F80_2000, 32'h80, 8'd9);
    access("R2", 1'b0, 2'd0, 32'h1F80_2010);
    cfg(4, 1, 32'h1F80_2000, 32'h80, 8'd9);
    // R3 overlap: RAM (1) beats video decoder (15)
    cfg(15, 1, 32'h0000_0000, 32'h0000_0100, 8'd11);
    access("R3", 1'b0, 2'd2, 32'h0000_0040);
    cfg(1, 0, 32'h0, 32'h0020_0000, 8'd4);
    access("R3", 1'b0, 2'd2, 32'h0000_0040);
    cfg(1, 1, 32'h0, 32'h0020_0000, 8'd4);
    cfg(15, 1, 32'h1F80_1820, 32'h8, 8'd2);
    // R4 misalignment per size
    access("R4", 1'b0, 2'd2, 32'h0000_0102);
    access("R4", 1'b0, 2'd3, 32'h0000_0101);
    access("R4", 1'b1, 2'd1, 32'h0000_0103);
    access("R4", 1'b0, 2'd0, 32'h0000_0103);
    access("R4", 1'b0, 2'd1, 32'h0000_0102);
    // R5 latency defaults
    access("R5", 1'b0, 2'd2, 32'h1FC0_0000);
    access("R5", 1'b0, 2'd2, 32'h1F00_F000 | 32'h0010_0000);
    access("R5", 1'b0, 2'd0, 32'h1F70_0000);
    access("R5", 1'b0, 2'd2, 32'h1F70_0000);
    access("R5", 1'b1, 2'd2, 32'h1F70_0000);
    access("R5", 1'b1, 2'd2, 32'h1F80_1C00);
    // R6 fallback constants and unmapped zero
    access("R6", 1'b0, 2'd1, 32'h1F80_1054);
    access("R6", 1'b0, 2'd1, 32'hBF40_0004);
    access("R6", 1'b0, 2'd1, 32'h9F40_0006);
    access("R6", 1'b0, 2'd1, 32'h1F80_105A);
    access("R6", 1'b0, 2'd2, 32'h1F80_1054);
    access("R6", 1'b1, 2'd1, 32'h1F80_1054);
    access("R6", 1'b0, 2'd1, 32'h1F80_1058);
    // R7 clear-on-read
    access("R7", 1'b0, 2'd2, 32'h1FC0_0000);
    lat_read("R7");
    access("R7", 1'b0, 2'd2, 32'h1F70_0000);
    chk("R7", "stale after clear", 64'(lat_o), 64'd0);
    // R7 simultaneous clear and unmatched word read: ends at 0
    access("R7", 1'b0, 2'd1, 32'h1F70_0000);
    @(negedge clk_i);
    lat_rd_i = 1'b1; req_valid_i = 1'b1; req_write_i = 1'b0; req_size_i = 2'd2; req_addr_i = 32'h1F70_0000;
    @(negedge clk_i);
    lat_rd_i = 1'b0; req_valid_i = 1'b0;
    chk("R7", "clear then word read", 64'(lat_o), 64'd0);
    // R7 simultaneous clear and mapped read: delay loaded
    @(negedge clk_i);
    lat_rd_i = 1'b1; req_valid_i = 1'b1; req_size_i = 2'd0; req_addr_i = 32'h1F80_1800;
    @(negedge clk_i);
    lat_rd_i = 1'b0; req_valid_i = 1'b0;
    chk("R7", "clear then mapped", 64'(lat_o), 64'd6);
    m_lat = 8'd6;
    // R8 idle cycle zeroes response
    @(negedge clk_i);
    chk("R8", "idle valid", 64'(rsp_valid_o), 64'd0);
    chk("R8", "idle sel", 64'(rsp_sel_o), 64'd0);
    chk("R8", "idle off", 64'(rsp_off_o), 64'd0);
    // R9 config write while busy is ignored
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 4'd13; cfg_en_i = 1'b0; cfg_base_i = 32'h0; cfg_size_i = 32'h0; cfg_dly_i = 8'd0;
    req_valid_i = 1'b1; req_write_i = 1'b0; req_size_i = 2'd0; req_addr_i = 32'h0000_0000;
    @(negedge clk_i);
    cfg_we_i = 1'b0; req_valid_i = 1'b0;
    m_lat = 8'd4;
    access("R9", 1'b0, 2'd0, 32'h1F80_1802);

    // Random mix, R1 R2 R3 R4 R5 R6
    void'($urandom(32'h1357_9BDF));
    for (int n = 0; n < 600; n++) begin
      int          w;
      logic [31:0] pa, va;
      logic [1:0]  sz;
      w  = int'($urandom_range(0, NW - 1));
      sz = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0: pa = $urandom;
        1: pa = m_base[w] + m_size[w] - 32'($urandom_range(0, 3)) + 32'($urandom_range(0, 2));
        default: pa = m_base[w] + ($urandom % m_size[w]);
      endcase
      va = pa;
      if (pa[31:29] == 3'd0) begin
        case ($urandom_range(0, 2))
          0: va = pa;
          1: va = pa | 32'h8000_0000;
          default: va = pa | 32'hA000_0000;
        endcase
      end
      if ($urandom_range(0, 9) == 0 && !m_lat[7]) lat_read("R7");
      access("RND", 1'($urandom_range(0, 1)), sz, va);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule